// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block turns a virtual page number into a physical frame by walking a hashed page table kept in ordinary memory. A request carries a virtual address. The page-number part is folded into a bucket index, and the bucket's head word gives the first element of a collision chain. The walker then visits elements in order until an element's stored page number equals the request. It returns the frame from that element, joined to the untouched page offset. A zero link, or a chain longer than a set bound, ends the walk with a fault.

Requests and responses use a valid/ready handshake. The table is read through a simple one-outstanding read port: a request is held with a stable address until the memory acknowledges it with data. The table is built and maintained by other agents. This block only reads it.

Each element spans three consecutive words. The walker reads the page-number word first. When that word does not match, it skips the frame word and fetches the link word straight away. A mismatched element therefore costs two reads and a matching element costs two reads.

Top module: `hpt_walker`

## Requirements
- R1: Out of reset the walker is idle: req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: The bucket index is the low IDX_W bits of (upper half of the page number XOR lower half of the page number). The first read of every walk is the head word at HEAD_BASE + index.
- R3: An element at pointer p stores its page number in word p (low VPN_W bits), its frame number in word p+1 (low PFN_W bits) and its next pointer in word p+2 (low AW bits).
- R4: When an element's page number equals the request, the response has rsp_fault 0 and rsp_paddr = {frame, request offset}.
- R5: When an element's page number differs from the request, the frame word is not read. The next read is word p+2, so each mismatched element costs exactly two reads.
- R6: A zero value read from either the head word or a next-pointer word ends the walk with rsp_fault 1 and rsp_paddr 0.
- R7: The walker examines at most MAX_CHAIN elements per lookup. A nonzero link met after MAX_CHAIN elements ends the walk with rsp_fault 1, and that element is not read.
- R8: req_ready is high only while idle. rsp_valid stays high, with rsp_fault and rsp_paddr unchanged, until rsp_ready is seen.
- R9: mem_req stays high with an unchanged mem_addr until mem_ack. Only one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above the offset |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_fault | output | 1 | 1 when no matching element was found |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit, 0 on a fault |
| mem_req | output | 1 | Table read request |
| mem_addr | output | AW | Table word address |
| mem_ack | input | 1 | Read accepted; mem_rdata valid this cycle |
| mem_rdata | input | DW | Table word read |

## Verification
The bench builds the walker with an 8-bit page number, four buckets, a head table based at word 4, 16-bit words and MAX_CHAIN of 3. With these values every one of the 256 page numbers can be looked up.

The chains are built in three shapes: one bucket empty, one holding a single element, and two holding five elements each. This places hits at every depth, mismatches running into a null link, and elements lying past the step bound.

A self-linked element placed in the empty bucket checks that the bound also stops a looping chain. The bench varies memory latency from zero to two cycles, adds stalls on the response side, and checks the read count of every lookup against the expected read cost.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_HEAD,
    WK_KEY,
    WK_FRAME,
    WK_LINK,
    WK_DONE
  } walk_state_t;

  localparam int unsigned SLOT_KEY   = 0;
  localparam int unsigned SLOT_FRAME = 1;
  localparam int unsigned SLOT_LINK  = 2;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned IDX_W = 10
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int unsigned HALF = VPN_W / 2;
  logic [HALF-1:0] folded;

  function automatic logic [HALF-1:0] fold_halves(input logic [VPN_W-1:0] v);
    return v[HALF-1:0] ^ v[2*HALF-1:HALF];
  endfunction

  assign folded = fold_halves(vpn);
  assign idx    = folded[IDX_W-1:0];
endmodule

// File: rtl/hpt_step_ctr.sv
module hpt_step_ctr #(
  parameter int unsigned MAX_CHAIN = 16,
  localparam int unsigned CW = $clog2(MAX_CHAIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + 1'b1;
  end

  assign at_limit = (count == CW'(MAX_CHAIN));
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned HEAD_BASE = 0
) (
  input  walk_state_t      state,
  input  logic [IDX_W-1:0] idx,
  input  logic [AW-1:0]    elem,
  output logic [AW-1:0]    addr
);
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] p, input int unsigned slot);
    return p + AW'(slot);
  endfunction

  always_comb begin
    unique case (state)
      WK_HEAD:  addr = AW'(HEAD_BASE) + AW'(idx);
      WK_KEY:   addr = slot_addr(elem, SLOT_KEY);
      WK_FRAME: addr = slot_addr(elem, SLOT_FRAME);
      WK_LINK:  addr = slot_addr(elem, SLOT_LINK);
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned PFN_W     = 20,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_CHAIN = 16,
  parameter int unsigned HEAD_BASE = 0,
  localparam int unsigned VA_W     = VPN_W + OFF_W,
  localparam int unsigned PA_W     = PFN_W + OFF_W,
  localparam int unsigned CW       = $clog2(MAX_CHAIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);
  walk_state_t      state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic [AW-1:0]    elem_q;
  logic [PA_W-1:0]  paddr_q;
  logic             fault_q;
  logic [IDX_W-1:0] bucket;

  // Named internal events, visible to the bound checker
  logic          accept_evt;
  logic          rd_fire;
  logic          link_fire;
  logic          null_evt;
  logic          limit_evt;
  logic          step_evt;
  logic          key_match;
  logic          hit_evt;
  logic [CW-1:0] visit_cnt;
  logic          at_limit;
  logic [AW-1:0] link_ptr;

  hpt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn (vpn_q),
    .idx (bucket)
  );

  hpt_addr_gen #(.AW(AW), .IDX_W(IDX_W), .HEAD_BASE(HEAD_BASE)) u_addr (
    .state (state_q),
    .idx   (bucket),
    .elem  (elem_q),
    .addr  (mem_addr)
  );

  hpt_step_ctr #(.MAX_CHAIN(MAX_CHAIN)) u_steps (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept_evt),
    .step     (step_evt),
    .count    (visit_cnt),
    .at_limit (at_limit)
  );

  assign req_ready  = (state_q == WK_IDLE);
  assign rsp_valid  = (state_q == WK_DONE);
  assign rsp_fault  = fault_q;
  assign rsp_paddr  = paddr_q;
  assign mem_req    = (state_q == WK_HEAD) || (state_q == WK_KEY) ||
                      (state_q == WK_FRAME) || (state_q == WK_LINK);

  assign accept_evt = req_valid && req_ready;
  assign rd_fire    = mem_req && mem_ack;
  assign link_ptr   = mem_rdata[AW-1:0];
  assign link_fire  = rd_fire && ((state_q == WK_HEAD) || (state_q == WK_LINK));
  assign null_evt   = link_fire && (link_ptr == '0);
  assign limit_evt  = link_fire && (link_ptr != '0) && at_limit;
  assign step_evt   = link_fire && (link_ptr != '0) && !at_limit;
  assign key_match  = (mem_rdata[VPN_W-1:0] == vpn_q);
  assign hit_evt    = rd_fire && (state_q == WK_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      elem_q  <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (accept_evt) begin
          vpn_q   <= req_vaddr[VA_W-1:OFF_W];
          off_q   <= req_vaddr[OFF_W-1:0];
          state_q <= WK_HEAD;
        end
        WK_HEAD, WK_LINK: if (rd_fire) begin
          if (null_evt || limit_evt) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            state_q <= WK_DONE;
          end else begin
            elem_q  <= link_ptr;
            state_q <= WK_KEY;
          end
        end
        WK_KEY: if (rd_fire) begin
          state_q <= key_match ? WK_FRAME : WK_LINK;
        end
        WK_FRAME: if (rd_fire) begin
          paddr_q <= {mem_rdata[PFN_W-1:0], off_q};
          fault_q <= 1'b0;
          state_q <= WK_DONE;
        end
        WK_DONE: if (rsp_ready) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned PFN_W     = 20,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned AW        = 32,
  parameter int unsigned MAX_CHAIN = 16,
  parameter int unsigned HEAD_BASE = 0,
  parameter int unsigned CW        = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VPN_W+OFF_W-1:0] req_vaddr,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic                   rsp_fault,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input logic                   mem_req,
  input logic [AW-1:0]          mem_addr,
  input logic                   mem_ack,
  input logic                   null_evt,
  input logic                   limit_evt,
  input logic                   hit_evt,
  input logic [CW-1:0]          visit_cnt
);
  function automatic logic [AW-1:0] head_of(input logic [VPN_W+OFF_W-1:0] va);
    logic [VPN_W-1:0] v;
    logic [VPN_W-1:0] mix;
    v   = va[VPN_W+OFF_W-1:OFF_W];
    mix = (v >> (VPN_W / 2)) ^ v;
    return AW'(HEAD_BASE) + AW'(mix % (1 << IDX_W));
  endfunction

  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);

  a_r2_head_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req && (mem_addr == head_of($past(req_vaddr))));

  a_r4_hit_response: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> rsp_valid && !rsp_fault);

  a_r6_null_fault: assert property (@(posedge clk) disable iff (!rst_n)
    null_evt |=> rsp_valid && rsp_fault && (rsp_paddr == '0));

  a_r7_limit_fault: assert property (@(posedge clk) disable iff (!rst_n)
    limit_evt |=> rsp_valid && rsp_fault);

  a_r7_visit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    visit_cnt <= CW'(MAX_CHAIN));

  a_r8_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr));

  a_r8_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));
endmodule

bind hpt_walker hpt_walker_chk #(
  .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .IDX_W(IDX_W), .AW(AW),
  .MAX_CHAIN(MAX_CHAIN), .HEAD_BASE(HEAD_BASE), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .null_evt(null_evt),
  .limit_evt(limit_evt), .hit_evt(hit_evt), .visit_cnt(visit_cnt)
);

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
  localparam int VPN_W = 8, OFF_W = 4, PFN_W = 8, IDX_W = 2;
  localparam int AW = 8, DW = 16, MAXC = 3, HBASE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [11:0] req_vaddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic rsp_fault;
  logic [11:0] rsp_paddr;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_ack;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem [256];
  int lat = 0;
  int wait_cnt = 0;
  int rd_cnt = 0;
  int checks = 0;
  int fails = 0;

  int ref_len [4];
  logic [7:0] ref_vpn [4][8];
  logic [7:0] ref_pfn [4][8];
  int tail_ptr [4];
  int next_free = 16;

  always #2 clk = ~clk;

  hpt_walker #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .IDX_W(IDX_W), .AW(AW),
    .DW(DW), .MAX_CHAIN(MAXC), .HEAD_BASE(HBASE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign mem_ack   = mem_req && (wait_cnt >= lat);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
    else                     wait_cnt <= 0;
    if (mem_req && mem_ack)  rd_cnt <= rd_cnt + 1;
  end

  function automatic int bucket_of(input int v);
    return ((v / 16) ^ (v % 16)) % 4;
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_entry(input int v, input int p);
    int b;
    b = bucket_of(v);
    mem[next_free]     = 16'(v);
    mem[next_free + 1] = 16'(p);
    mem[next_free + 2] = 16'h0;
    if (ref_len[b] == 0) mem[HBASE + b] = 16'(next_free);
    else                 mem[tail_ptr[b] + 2] = 16'(next_free);
    tail_ptr[b] = next_free;
    ref_vpn[b][ref_len[b]] = 8'(v);
    ref_pfn[b][ref_len[b]] = 8'(p);
    ref_len[b]++;
    next_free += 3;
  endtask

  task automatic lookup(input int v, input int off, input int lat_i, input int hold,
                        output logic f, output logic [11:0] pa, output int nreads);
    lat = lat_i;
    @(negedge clk);
    req_vaddr = {8'(v), 4'(off)};
    req_valid = 1'b1;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 busy ready low", req_ready == 1'b0, req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    f = rsp_fault;
    pa = rsp_paddr;
    nreads = rd_cnt;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R8 response held", rsp_valid && rsp_paddr == pa && rsp_fault == f,
            rsp_paddr, pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R8 idle after response", req_ready == 1'b1 && !rsp_valid, req_ready, 1);
  endtask

  initial begin
    logic f;
    logic [11:0] pa;
    int nr;
    for (int a = 0; a < 256; a++) mem[a] = 16'h0;
    for (int b = 0; b < 4; b++) ref_len[b] = 0;
    // R3 layout: key word, frame word, link word
    for (int v = 0; v < 256; v++) begin
      int b;
      b = bucket_of(v);
      if (v % 7 == 0 && b != 2 && ref_len[b] < ((b == 1) ? 1 : 5))
        add_entry(v, v ^ 8'hA5);
    end

    repeat (3) @(negedge clk);
    check("R1 reset ready", req_ready == 1'b1, req_ready, 1);
    check("R1 reset rsp_valid", rsp_valid == 1'b0, rsp_valid, 0);
    check("R1 reset mem_req", mem_req == 1'b0, mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", req_ready && !mem_req, req_ready, 1);

    // Sweep every page number: R2 R4 R5 R6 R7 R9
    for (int v = 0; v < 256; v++) begin
      int b;
      int exp_reads;
      logic exp_f;
      logic [11:0] exp_pa;
      int off;
      off = (v * 5) % 16;
      b = bucket_of(v);
      exp_reads = 1;
      exp_f = 1'b1;
      exp_pa = '0;
      for (int i = 0; i < ref_len[b]; i++) begin
        if (i == MAXC) break;
        exp_reads += 2;
        if (ref_vpn[b][i] == 8'(v)) begin
          exp_f = 1'b0;
          exp_pa = {ref_pfn[b][i], 4'(off)};
          break;
        end
      end
      lookup(v, off, v % 3, v % 2, f, pa, nr);
      check("R4 R6 R7 fault flag", f == exp_f, f, exp_f);
      check("R4 physical address", pa == exp_pa, pa, exp_pa);
      check("R2 R5 R9 read count", nr == exp_reads, nr, exp_reads);
    end

    // R7 self-linked element in the empty bucket stops at the bound
    mem[200] = 16'h00FF;
    mem[201] = 16'h0011;
    mem[202] = 16'd200;
    mem[HBASE + 2] = 16'd200;
    lookup(2, 3, 1, 0, f, pa, nr);
    check("R7 loop fault", f == 1'b1, f, 1);
    check("R7 loop reads", nr == 1 + 2 * MAXC, nr, 1 + 2 * MAXC);

    // R5 the key is matched on the low VPN_W bits only
    mem[200] = 16'hAB02;
    lookup(2, 9, 2, 1, f, pa, nr);
    check("R5 upper key bits ignored", f == 1'b0 && pa == 12'h119, pa, 12'h119);
    check("R5 hit read count", nr == 3, nr, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule